// File: doc/BRIEF.md
# Shadow-Set General Register File

This block is the general-purpose register storage of a processor with several banked register sets. Each set holds 32 registers. An instruction pipeline reads two operands and writes one result per cycle, all inside the set chosen by the current-set index. A separate operation path moves data across sets, into or out of the set chosen by the previous-set index. Interrupt entry code uses this path to reach the state of the interrupted context.

Register zero gets special treatment. The normal write port never changes it. A read of it gives constant zero only while the external "r0 known zero" input is high. When that input is low, the read gives whatever the selected set holds. The cross-set operations are privileged and only exist when the external interrupt controller strap is set. When they are refused, the block raises an exception request with a cause code, and no register changes. A cross-set write that may have put a nonzero value into some set's r0 raises a one-cycle recheck pulse, so that the surrounding logic can recompute the "r0 known zero" flag.

Top module: `shadow_regfile`

## Requirements
- R1: After reset, every register of every set reads as zero, including r0 while r0_is_zero is low.
- R2: Reads on both ports and writes on the normal port address the set given by crs. A value written in one set is not visible in another set. A write becomes readable on the cycle after the clock edge.
- R3: A normal-port write to address 0 is discarded. So is a read-previous operation whose destination is 0.
- R4: A read of address 0 returns zero when r0_is_zero is high. When it is low, the read returns the value stored in r0 of the current set.
- R5: A read of the register being written in the same cycle returns the value it held before that write.
- R6: Read-previous (px_op = 1) writes, at the clock edge, the stored value of register px_src in set prs plus px_imm sign-extended from 16 bits into register px_dst of set crs. This path does not apply the r0 rule.
- R7: Write-previous (px_op = 2) copies the current-set read value of px_src into register px_dst of set prs. This value follows the r0 rule of R4. This operation may write r0.
- R8: A cross-set operation while eic_present is low raises exc_req with exc_cause = 1 (illegal instruction) and changes no register. This cause takes priority over the one in R9.
- R9: A cross-set operation in user mode (user_mode high) with eic_present high raises exc_req with exc_cause = 2 (supervisor only) and changes no register.
- R10: r0_recheck is high exactly when a write-previous operation is accepted, targets px_dst = 0, and either has px_src nonzero or has r0_is_zero low.
- R11: In a cycle where px_op is 1 or 2, the normal write port is ignored, whether or not the operation is accepted.
- R12: With px_op at 0 or 3, exc_req is low and exc_cause is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crs | input | SW | Current register set index |
| prs | input | SW | Previous register set index |
| user_mode | input | 1 | High in user mode |
| eic_present | input | 1 | Strap: cross-set operations exist |
| r0_is_zero | input | 1 | r0 of the current set is known to hold zero |
| rd_a_addr | input | 5 | Read port A address |
| rd_a_data | output | DW | Read port A data |
| rd_b_addr | input | 5 | Read port B address |
| rd_b_data | output | DW | Read port B data |
| wr_en | input | 1 | Normal write enable |
| wr_addr | input | 5 | Normal write address |
| wr_data | input | DW | Normal write data |
| px_op | input | 2 | Cross-set operation: 0 none, 1 read-previous, 2 write-previous, 3 none |
| px_src | input | 5 | Cross-set source register |
| px_dst | input | 5 | Cross-set destination register |
| px_imm | input | 16 | Signed offset for read-previous |
| exc_req | output | 1 | Exception request |
| exc_cause | output | 2 | 0 none, 1 illegal, 2 supervisor only |
| r0_recheck | output | 1 | Pulse: the r0-zero flag must be recomputed |

## Verification
The bench uses the default parameters: four sets of 32 registers, 32 bits wide, with 2-bit set indices. Four sets are few enough that random crs and prs values often land on the same set. This exercises the case where a write-previous lands in the set that is being read. It is also how an r0 written across sets shows up on the normal read ports. With four sets the whole storage is small, so random addresses revisit registers often, and the same-cycle read-during-write case and reads of r0 both come up many times in the random stream.

// File: rtl/shadow_regfile.sv
module shadow_regfile #(
  parameter int NSETS = 4,
  parameter int DW = 32,
  localparam int SW = (NSETS > 1) ? $clog2(NSETS) : 1,
  localparam int DEPTH = (1 << SW) * 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] crs,
  input  logic [SW-1:0] prs,
  input  logic          user_mode,
  input  logic          eic_present,
  input  logic          r0_is_zero,
  input  logic [4:0]    rd_a_addr,
  output logic [DW-1:0] rd_a_data,
  input  logic [4:0]    rd_b_addr,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [4:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    px_op,
  input  logic [4:0]    px_src,
  input  logic [4:0]    px_dst,
  input  logic [15:0]   px_imm,
  output logic          exc_req,
  output logic [1:0]    exc_cause,
  output logic          r0_recheck
);
  localparam logic [1:0] OP_RDP = 2'd1;
  localparam logic [1:0] OP_WRP = 2'd2;

  logic [DW-1:0] regs [DEPTH];

  logic          px_valid, px_ok;
  logic [DW-1:0] cur_src, prev_src, prev_sum;

  function automatic logic [DW-1:0] rd_cur(input logic [SW-1:0] s, input logic [4:0] a,
                                           input logic z, input logic [DW-1:0] v);
    return (a == 5'd0 && z) ? '0 : v;
  endfunction

  assign rd_a_data = rd_cur(crs, rd_a_addr, r0_is_zero, regs[{crs, rd_a_addr}]);
  assign rd_b_data = rd_cur(crs, rd_b_addr, r0_is_zero, regs[{crs, rd_b_addr}]);
  assign cur_src   = rd_cur(crs, px_src, r0_is_zero, regs[{crs, px_src}]);
  assign prev_src  = regs[{prs, px_src}];
  assign prev_sum  = prev_src + {{(DW-16){px_imm[15]}}, px_imm};

  assign px_valid  = (px_op == OP_RDP) || (px_op == OP_WRP);
  assign exc_cause = !px_valid ? 2'd0 : !eic_present ? 2'd1 : user_mode ? 2'd2 : 2'd0;
  assign exc_req   = exc_cause != 2'd0;
  assign px_ok     = px_valid && !exc_req;

  assign r0_recheck = px_ok && px_op == OP_WRP && px_dst == 5'd0 &&
                      (px_src != 5'd0 || !r0_is_zero);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (px_ok && px_op == OP_RDP) begin
      if (px_dst != 5'd0) regs[{crs, px_dst}] <= prev_sum;
    end else if (px_ok && px_op == OP_WRP) begin
      regs[{prs, px_dst}] <= cur_src;
    end else if (!px_valid && wr_en && wr_addr != 5'd0) begin
      regs[{crs, wr_addr}] <= wr_data;
    end
  end
endmodule

module shadow_regfile_chk #(
  parameter int SW = 2,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [SW-1:0] crs,
  input logic          user_mode,
  input logic          eic_present,
  input logic          r0_is_zero,
  input logic [4:0]    rd_a_addr,
  input logic [DW-1:0] rd_a_data,
  input logic          wr_en,
  input logic [4:0]    wr_addr,
  input logic [DW-1:0] wr_data,
  input logic [1:0]    px_op,
  input logic [4:0]    px_src,
  input logic [4:0]    px_dst,
  input logic          exc_req,
  input logic [1:0]    exc_cause,
  input logic          r0_recheck
);
  logic xop;
  assign xop = px_op == 2'd1 || px_op == 2'd2;

  AST_ILLEGAL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    xop && !eic_present |-> exc_req && exc_cause == 2'd1); // R8

  AST_USER_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    xop && eic_present && user_mode |-> exc_req && exc_cause == 2'd2); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !xop |-> !exc_req && exc_cause == 2'd0); // R12

  AST_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr != 5'd0 && !xop |=>
      (!($stable(crs) && rd_a_addr == $past(wr_addr)) || rd_a_data == $past(wr_data))); // R2

  AST_RECHECK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    r0_recheck |-> px_op == 2'd2 && !exc_req && px_dst == 5'd0 &&
                   (px_src != 5'd0 || !r0_is_zero)); // R10
endmodule

bind shadow_regfile shadow_regfile_chk #(.SW(SW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .crs(crs), .user_mode(user_mode),
  .eic_present(eic_present), .r0_is_zero(r0_is_zero),
  .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .px_op(px_op), .px_src(px_src), .px_dst(px_dst),
  .exc_req(exc_req), .exc_cause(exc_cause), .r0_recheck(r0_recheck));

// File: tb/shadow_regfile_test.sv
module shadow_regfile_test;
  localparam int NS = 4;

  logic clk = 0, rst_n = 0;
  logic [1:0] crs = 0, prs = 0;
  logic user_mode = 0, eic_present = 1, r0_is_zero = 1;
  logic [4:0] rd_a_addr = 0, rd_b_addr = 0, wr_addr = 0, px_src = 0, px_dst = 0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = 0;
  logic wr_en = 0;
  logic [1:0] px_op = 0;
  logic [15:0] px_imm = 0;
  logic exc_req, r0_recheck;
  logic [1:0] exc_cause;

  int checks = 0, errors = 0;
  logic [31:0] m [NS][32];

  always #5 clk = ~clk;

  shadow_regfile uut (
    .clk(clk), .rst_n(rst_n), .crs(crs), .prs(prs), .user_mode(user_mode),
    .eic_present(eic_present), .r0_is_zero(r0_is_zero),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .px_op(px_op), .px_src(px_src), .px_dst(px_dst), .px_imm(px_imm),
    .exc_req(exc_req), .exc_cause(exc_cause), .r0_recheck(r0_recheck));

  function automatic logic [31:0] mread(input logic [1:0] s, input logic [4:0] a, input logic z);
    return (a == 0 && z) ? 32'd0 : m[s][a];
  endfunction

  function automatic logic [1:0] mcause(input logic [1:0] op, input logic eic, input logic usr);
    if (op != 2'd1 && op != 2'd2) return 2'd0;
    if (!eic) return 2'd1;
    if (usr) return 2'd2;
    return 2'd0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input logic [1:0] c, p, input logic usr, eic, z,
                     input logic [4:0] ra, rb, input logic we, input logic [4:0] wa,
                     input logic [31:0] wd, input logic [1:0] op,
                     input logic [4:0] s, d, input logic [15:0] im);
    logic [1:0] ec;
    logic rc;
    @(negedge clk);
    crs = c; prs = p; user_mode = usr; eic_present = eic; r0_is_zero = z;
    rd_a_addr = ra; rd_b_addr = rb; wr_en = we; wr_addr = wa; wr_data = wd;
    px_op = op; px_src = s; px_dst = d; px_imm = im;
    #1;
    ec = mcause(op, eic, usr);
    rc = (op == 2'd2) && ec == 0 && d == 0 && (s != 0 || !z);
    check(tag, rd_a_data, mread(c, ra, z));
    check(tag, rd_b_data, mread(c, rb, z));
    check(ec == 1 ? "R8" : ec == 2 ? "R9" : "R12", {29'd0, exc_req, exc_cause}, {29'd0, ec != 0, ec});
    check("R10", {31'd0, r0_recheck}, {31'd0, rc});
    if (op == 2'd1 && ec == 0) begin
      if (d != 0) m[c][d] = m[p][s] + {{16{im[15]}}, im};
    end else if (op == 2'd2 && ec == 0) begin
      m[p][d] = mread(c, s, z);
    end else if (op != 2'd1 && op != 2'd2 && we && wa != 0) begin
      m[c][wa] = wd;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) for (int a = 0; a < 32; a++) m[s][a] = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int s = 0; s < NS; s++) for (int a = 0; a < 32; a++) m[s][a] = 0;
    // R1: reset clears everything, r0 stored value visible with flag low
    for (int s = 0; s < NS; s++)
      for (int a = 0; a < 32; a += 2)
        cyc("R1", s[1:0], 0, 0, 1, 0, a[4:0], a[4:0] + 5'd1, 0, 0, 0, 0, 0, 0, 0);
    // R5: same-cycle read returns old value; R2: visible next cycle, not in other set
    cyc("R5", 1, 0, 0, 1, 1, 7, 7, 1, 7, 32'hA5A5_0001, 0, 0, 0, 0);
    cyc("R2", 1, 0, 0, 1, 1, 7, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R2", 2, 0, 0, 1, 1, 7, 7, 0, 0, 0, 0, 0, 0, 0);
    // R3: normal write to r0 dropped
    cyc("R3", 1, 0, 0, 1, 0, 0, 0, 1, 0, 32'h1234_5678, 0, 0, 0, 0);
    cyc("R3", 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R7/R10: write-previous into r0 of set 2
    cyc("R7", 1, 2, 0, 1, 1, 7, 0, 0, 0, 0, 2, 7, 0, 0);
    cyc("R4", 2, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R4", 2, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R7: source r0 with flag high copies zero, no recheck
    cyc("R7", 1, 3, 0, 1, 1, 0, 0, 0, 0, 0, 2, 0, 4, 0);
    cyc("R7", 3, 0, 0, 1, 0, 4, 0, 0, 0, 0, 0, 0, 0, 0);
    // R6: read-previous with negative offset
    cyc("R6", 3, 1, 0, 1, 1, 9, 0, 0, 0, 0, 1, 7, 9, 16'hFFFE);
    cyc("R6", 3, 1, 0, 1, 1, 9, 9, 0, 0, 0, 0, 0, 0, 0);
    // R3: read-previous to r0 dropped
    cyc("R3", 3, 1, 0, 1, 1, 0, 0, 0, 0, 0, 1, 7, 0, 16'h0010);
    cyc("R3", 3, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R8: illegal wins over user mode, no state change
    cyc("R8", 3, 1, 1, 0, 1, 9, 0, 0, 0, 0, 1, 7, 9, 16'h0100);
    cyc("R8", 3, 1, 0, 1, 1, 9, 0, 0, 0, 0, 0, 0, 0, 0);
    // R9: supervisor-only, no state change
    cyc("R9", 1, 3, 1, 1, 1, 0, 0, 0, 0, 0, 2, 7, 4, 0);
    cyc("R9", 3, 1, 0, 1, 1, 4, 0, 0, 0, 0, 0, 0, 0, 0);
    // R11: normal write ignored during cross-set op, even when refused
    cyc("R11", 0, 1, 1, 1, 1, 5, 0, 1, 5, 32'hCAFE_0005, 2, 0, 3, 0);
    cyc("R11", 0, 1, 0, 1, 1, 5, 0, 1, 5, 32'hCAFE_0006, 1, 0, 3, 0);
    cyc("R11", 0, 1, 0, 1, 1, 5, 3, 0, 0, 0, 0, 0, 0, 0);
    // R12: op code 3 is idle, normal write proceeds
    cyc("R12", 0, 1, 1, 0, 1, 5, 0, 1, 5, 32'hCAFE_0007, 3, 0, 0, 0);
    cyc("R12", 0, 1, 0, 1, 1, 5, 0, 0, 0, 0, 0, 0, 0, 0);

    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] op;
      int r;
      r = $urandom_range(0, 9);
      op = (r < 6) ? 2'd0 : (r < 8) ? 2'd1 : (r < 9) ? 2'd2 : 2'd3;
      cyc("R2", 2'($urandom), 2'($urandom), $urandom_range(0, 3) == 0,
          $urandom_range(0, 7) != 0, $urandom_range(0, 3) != 0,
          5'($urandom), 5'($urandom), $urandom_range(0, 1) == 1,
          5'($urandom_range(0, 7)), $urandom, op,
          5'($urandom_range(0, 7)), 5'($urandom_range(0, 7)), 16'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule